// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Controller

This block takes up to 64 interrupt request lines. Each line has a mask bit, a 3-bit level (1 to 7) and a 3-bit priority within that level, all set through a small configuration write port. When an acknowledge is accepted, the block picks a winning source among the active, unmasked lines and returns that source's vector number as a byte. The vector is a fixed base plus the source index. At the same clock edge it records the winner's level and priority in a capture register, which software can read back later.

Acknowledges reach the block in two ways. The first is a register read channel. Address 0 is the software acknowledge, which searches all levels. Addresses 1 to 7 are the per-level acknowledges, which search one level only. Address 8 reads the capture register. The second way is a processor acknowledge channel that carries a level, and it acts exactly like a read of that level's register. A service routine can issue a software acknowledge near its end to find more pending work without taking a new exception.

Requests and responses use valid/ready handshakes. The response side is a single-entry slot. A new request is accepted only when the slot is empty, or when it is being emptied in the same cycle. A held response keeps its data stable until the consumer takes it. Whenever the processor channel is valid, it has precedence over the read channel.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset every source is masked with level 0 and priority 0, no response is pending, and the capture register reads as 0.
- R2: A winning source with index i returns the vector 64 + i on rsp_data. When no source is eligible, an acknowledge returns 0.
- R3: A software acknowledge (rd_addr 0) picks the eligible source with the highest level. Among equal levels it picks the highest priority, and among equal level and priority it picks the lowest index.
- R4: A level-n acknowledge (rd_addr n, n = 1..7) considers only eligible sources whose level is n. It picks the highest priority there, and the lowest index on a tie.
- R5: A source is eligible only when its request is high, its mask bit is 0 and its level is not 0. Masked and level-0 sources never win.
- R6: Every accepted acknowledge loads the capture register on its accept edge with level in bits [5:3] and priority in bits [2:0]. When there is no winner it loads 0. rd_addr 8 returns the capture register in bits [5:0] and leaves it unchanged. rd_addr 9 to 15 return 0 and change nothing.
- R7: An acknowledge does not change any request or configuration, so a repeated acknowledge with unchanged inputs returns the same vector.
- R8: An accepted processor acknowledge with level n (1..7) gives the same vector and capture update as a read of rd_addr n. Level 0 returns 0 and clears the capture register.
- R9: While cpu_ack_valid is high, rd_ready is low.
- R10: The block accepts a request only when rsp_valid is low or rsp_ready is high. A response that is valid but not taken keeps rsp_valid high and rsp_data stable.
- R11: With cfg_we high, the mask, level and priority of source cfg_idx are written on the clock edge. An acknowledge accepted on that same edge still uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 64 | Request level of each source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Source index to configure |
| cfg_mask | input | 1 | Mask bit to write (1 = masked) |
| cfg_lvl | input | 3 | Level to write |
| cfg_pri | input | 3 | Priority to write |
| rd_valid | input | 1 | Register read request valid |
| rd_ready | output | 1 | Register read request accepted |
| rd_addr | input | 4 | Register select: 0 software, 1..7 level, 8 capture |
| cpu_ack_valid | input | 1 | Processor acknowledge valid |
| cpu_ack_ready | output | 1 | Processor acknowledge accepted |
| cpu_ack_lvl | input | 3 | Level of the processor acknowledge |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Vector or register contents |

## Verification
The assertions check the handshake rules on every cycle: a held response must stay stable, no request may be accepted while the slot is full, and the processor channel must block register reads. They also check that the capture register changes only on an accepted acknowledge and never holds a priority without a level. Only the bench's scenarios can show which source wins. This covers level-then-priority-then-index ordering, per-level filtering, masking, the zero vector, and the use of old settings when a configuration write and an acknowledge land on the same edge. The bench shows these by comparing every cycle against a behavioural model.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int KEY_W  = LVL_W + PRI_W;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_SW  = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_CAP = 4'd8;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [PRI_W-1:0] pri;
  } lp_t;
endpackage

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic                    cfg_mask,
  input  logic [LVL_W-1:0]        cfg_lvl,
  input  logic [PRI_W-1:0]        cfg_pri,
  output logic [NUM_SRC-1:0]      src_mask,
  output lp_t  [NUM_SRC-1:0]      src_lp
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit;
    assign hit = cfg_we && (cfg_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_mask[i] <= 1'b1;
        src_lp[i]   <= '0;
      end else if (hit) begin
        src_mask[i]     <= cfg_mask;
        src_lp[i].lvl   <= cfg_lvl;
        src_lp[i].pri   <= cfg_pri;
      end
    end
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_ack_pkg::*;
#(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N),
  localparam int LEAVES = 1 << IDX_W
) (
  input  logic [N-1:0]     elig,
  input  lp_t  [N-1:0]     key,
  output logic             win_v,
  output logic [IDX_W-1:0] win_idx,
  output lp_t              win_key
);
  for (genvar s = 0; s <= IDX_W; s++) begin : g_st
    localparam int W = LEAVES >> s;
    logic [W-1:0]       v;
    logic [KEY_W-1:0]   k  [W];
    logic [IDX_W-1:0]   ix [W];
    if (s == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_l
        if (j < N) begin : g_real
          assign v[j]  = elig[j];
          assign k[j]  = key[j];
          assign ix[j] = IDX_W'(j);
        end else begin : g_pad
          assign v[j]  = 1'b0;
          assign k[j]  = '0;
          assign ix[j] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_n
        logic take_r;
        // right child wins only on a strictly larger key; ties keep the lower index
        assign take_r = g_st[s-1].v[2*j+1] &&
                        (!g_st[s-1].v[2*j] || (g_st[s-1].k[2*j+1] > g_st[s-1].k[2*j]));
        assign v[j]  = g_st[s-1].v[2*j] | g_st[s-1].v[2*j+1];
        assign k[j]  = take_r ? g_st[s-1].k[2*j+1]  : g_st[s-1].k[2*j];
        assign ix[j] = take_r ? g_st[s-1].ix[2*j+1] : g_st[s-1].ix[2*j];
      end
    end
  end

  assign win_v   = g_st[IDX_W].v[0];
  assign win_idx = g_st[IDX_W].ix[0];
  assign win_key = g_st[IDX_W].k[0];
endmodule

// File: rtl/irq_ack_port.sv
module irq_ack_port
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int VEC_BASE = 64,
  parameter int VEC_W    = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cpu_ack_valid,
  output logic              cpu_ack_ready,
  input  logic [LVL_W-1:0]  cpu_ack_lvl,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VEC_W-1:0]  rsp_data,
  output logic              sel_sw,
  output logic [LVL_W-1:0]  sel_lvl,
  input  logic              win_v,
  input  logic [IDX_W-1:0]  win_idx,
  input  lp_t               win_key,
  output lp_t               lp_q
);
  logic slot_free, cpu_fire, rd_fire, rd_is_ack, ack_fire;
  logic [VEC_W-1:0] vec, reg_val;

  assign slot_free     = !rsp_valid || rsp_ready;
  assign cpu_ack_ready = slot_free;
  assign rd_ready      = slot_free && !cpu_ack_valid;
  assign cpu_fire      = cpu_ack_valid && slot_free;
  assign rd_fire       = rd_valid && rd_ready;
  assign rd_is_ack     = !rd_addr[ADDR_W-1];
  assign ack_fire      = cpu_fire || (rd_fire && rd_is_ack);

  always_comb begin
    if (cpu_ack_valid) begin
      sel_sw  = 1'b0;
      sel_lvl = cpu_ack_lvl;
    end else begin
      sel_sw  = (rd_addr == ADDR_SW);
      sel_lvl = rd_is_ack ? rd_addr[LVL_W-1:0] : '0;
    end
  end

  assign vec     = win_v ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;
  assign reg_val = (rd_addr == ADDR_CAP) ? VEC_W'(lp_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      lp_q      <= '0;
    end else begin
      if (ack_fire) begin
        rsp_valid <= 1'b1;
        rsp_data  <= vec;
        lp_q      <= win_v ? win_key : '0;
      end else if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_data  <= reg_val;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int VEC_BASE = 64,
  parameter int VEC_W    = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_mask,
  input  logic [2:0]         cfg_lvl,
  input  logic [2:0]         cfg_pri,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [3:0]         rd_addr,
  input  logic               cpu_ack_valid,
  output logic               cpu_ack_ready,
  input  logic [2:0]         cpu_ack_lvl,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VEC_W-1:0]   rsp_data
);
  logic [NUM_SRC-1:0] src_mask;
  lp_t  [NUM_SRC-1:0] src_lp;
  logic [NUM_SRC-1:0] elig;
  logic               sel_sw;
  logic [LVL_W-1:0]   sel_lvl;
  logic               win_v;
  logic [IDX_W-1:0]   win_idx;
  lp_t                win_key;
  lp_t                lp_q;

  irq_src_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_mask(cfg_mask), .cfg_lvl(cfg_lvl), .cfg_pri(cfg_pri),
    .src_mask(src_mask), .src_lp(src_lp)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = src_req[i] && !src_mask[i] && (src_lp[i].lvl != '0) &&
                     (sel_sw || (src_lp[i].lvl == sel_lvl));
  end

  irq_prio_tree #(.N(NUM_SRC)) u_tree (
    .elig(elig), .key(src_lp),
    .win_v(win_v), .win_idx(win_idx), .win_key(win_key)
  );

  irq_ack_port #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .cpu_ack_valid(cpu_ack_valid), .cpu_ack_ready(cpu_ack_ready), .cpu_ack_lvl(cpu_ack_lvl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sel_sw(sel_sw), .sel_lvl(sel_lvl),
    .win_v(win_v), .win_idx(win_idx), .win_key(win_key), .lp_q(lp_q)
  );
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [3:0]       rd_addr,
  input logic             cpu_ack_valid,
  input logic             cpu_ack_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [VEC_W-1:0] rsp_data,
  input logic [5:0]       lp_q
);
  logic ack_taken;
  assign ack_taken = (cpu_ack_valid && cpu_ack_ready) || (rd_valid && rd_ready && !rd_addr[3]);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !rd_ready && !cpu_ack_ready); // R10
  AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack_valid |-> !rd_ready); // R9
  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_taken |=> $stable(lp_q)); // R6
  AST_CAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_q[5:3] == 3'd0) |-> (lp_q[2:0] == 3'd0)); // R5
endmodule

bind irq_ack_ctrl irq_ack_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .cpu_ack_valid(cpu_ack_valid), .cpu_ack_ready(cpu_ack_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .lp_q(lp_q)
);

// File: tb/irq_ack_ctrl_bench.sv
module irq_ack_ctrl_bench;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_req = '0;
  logic cfg_we = 0, cfg_mask = 0;
  logic [5:0] cfg_idx = 0;
  logic [2:0] cfg_lvl = 0, cfg_pri = 0, cpu_ack_lvl = 0;
  logic rd_valid = 0, cpu_ack_valid = 0, rsp_ready = 1;
  logic [3:0] rd_addr = 0;
  logic rd_ready, cpu_ack_ready, rsp_valid;
  logic [7:0] rsp_data;

  irq_ack_ctrl u_irq_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_mask(cfg_mask), .cfg_lvl(cfg_lvl), .cfg_pri(cfg_pri),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .cpu_ack_valid(cpu_ack_valid), .cpu_ack_ready(cpu_ack_ready), .cpu_ack_lvl(cpu_ack_lvl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string scen = "R1";

  // behavioural model state
  bit m_mask [N];
  int m_lv [N], m_pr [N];
  bit m_full = 0;
  int m_data = 0, m_lp = 0;
  bit last_rf, last_cf;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", scen, what, act, exp);
    end
  endtask

  function automatic int pick(input bit sw, input int lvl);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (src_req[i] && !m_mask[i] && m_lv[i] != 0 && (sw || m_lv[i] == lvl))
        if (best < 0 || m_lv[i] > m_lv[best] ||
            (m_lv[i] == m_lv[best] && m_pr[i] > m_pr[best])) best = i;
    return best;
  endfunction

  task automatic take_ack(input bit sw, input int lvl);
    int w = pick(sw, lvl);
    m_data = (w < 0) ? 0 : 64 + w;
    m_lp   = (w < 0) ? 0 : m_lv[w] * 8 + m_pr[w];
    m_full = 1;
  endtask

  // compare the whole visible state every cycle, then advance the model across one edge
  task automatic tick();
    bit free;
    #1;
    free = !m_full || rsp_ready;
    chk(rsp_valid === m_full, "rsp_valid R10", rsp_valid, m_full);
    if (m_full) chk(rsp_data === 8'(m_data), "rsp_data", rsp_data, m_data);
    chk(cpu_ack_ready === free, "cpu_ack_ready R10", cpu_ack_ready, free);
    chk(rd_ready === (free && !cpu_ack_valid), "rd_ready R9", rd_ready, free && !cpu_ack_valid);
    last_cf = cpu_ack_valid && free;
    last_rf = rd_valid && free && !cpu_ack_valid;
    if (m_full && rsp_ready) m_full = 0;
    if (last_cf) take_ack(0, cpu_ack_lvl);
    else if (last_rf) begin
      if (rd_addr < 8) take_ack(rd_addr == 0, rd_addr);
      else begin m_data = (rd_addr == 8) ? m_lp : 0; m_full = 1; end
    end
    if (cfg_we) begin
      m_mask[cfg_idx] = cfg_mask; m_lv[cfg_idx] = cfg_lvl; m_pr[cfg_idx] = cfg_pri;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg(input int idx, input bit msk, input int lv, input int pr);
    cfg_we = 1; cfg_idx = 6'(idx); cfg_mask = msk; cfg_lvl = 3'(lv); cfg_pri = 3'(pr);
    tick();
    cfg_we = 0;
  endtask

  task automatic do_rd(input int a);
    rd_valid = 1; rd_addr = 4'(a);
    do tick(); while (!last_rf);
    rd_valid = 0;
    tick();
  endtask

  task automatic do_cpu(input int lv);
    cpu_ack_valid = 1; cpu_ack_lvl = 3'(lv);
    do tick(); while (!last_cf);
    cpu_ack_valid = 0;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_mask[i] = 1; m_lv[i] = 0; m_pr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: nothing pending, all masked, capture zero
    scen = "R1";
    #1 chk(rsp_valid === 1'b0, "reset rsp_valid", rsp_valid, 0);
    @(negedge clk);
    src_req = '1;
    do_rd(0);
    do_rd(8);
    tick();

    // R11: program sources
    scen = "R11";
    cfg(5, 0, 3, 2); cfg(9, 0, 3, 5); cfg(12, 0, 3, 5);
    cfg(20, 0, 6, 1); cfg(33, 0, 6, 1); cfg(40, 0, 1, 7);
    cfg(63, 1, 7, 0); cfg(2, 0, 0, 7);
    src_req = '0;
    src_req[5] = 1; src_req[9] = 1; src_req[12] = 1; src_req[20] = 1;
    src_req[33] = 1; src_req[40] = 1; src_req[63] = 1; src_req[2] = 1;

    scen = "R3"; do_rd(0);            // expect 64+20
    scen = "R6"; do_rd(8);            // expect 0x31
    scen = "R4";
    for (int l = 1; l < 8; l++) begin do_rd(l); do_rd(8); end
    scen = "R5"; cfg(63, 0, 7, 0); do_rd(0); do_rd(7); cfg(63, 1, 7, 0); do_rd(0);
    scen = "R7"; do_rd(3); do_rd(3); do_rd(0); do_rd(0);
    scen = "R8"; do_cpu(3); do_rd(8); do_cpu(6); do_cpu(0); do_rd(8);

    // R9: both channels at once, processor goes first
    scen = "R9";
    cpu_ack_valid = 1; cpu_ack_lvl = 1; rd_valid = 1; rd_addr = 3;
    tick();
    cpu_ack_valid = 0;
    do tick(); while (!last_rf);
    rd_valid = 0; tick(); tick();

    // R10: consumer stalls
    scen = "R10";
    rsp_ready = 0; rd_valid = 1; rd_addr = 0;
    tick();
    rd_addr = 4;
    repeat (3) tick();
    rsp_ready = 1; tick();
    rd_valid = 0; tick(); tick();

    // R11: write and acknowledge on the same edge uses old settings
    scen = "R11";
    cfg_we = 1; cfg_idx = 40; cfg_mask = 0; cfg_lvl = 2; cfg_pri = 7;
    rd_valid = 1; rd_addr = 1;
    tick();
    cfg_we = 0; rd_valid = 0; tick();
    do_rd(1); do_rd(2);

    // R2: no eligible source returns zero; R6 undefined address leaves capture alone
    scen = "R2"; do_rd(0); src_req = '0; do_rd(0); do_rd(5);
    scen = "R6"; src_req[20] = 1; do_rd(6); do_rd(9); do_rd(8);
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule